// File: doc/BRIEF.md
# Masked Packet Pattern Filter

The block compares the opening bytes of each received Ethernet frame against four programmable filters that work independently of each other. Each filter keeps a pattern of up to 128 bytes and a per-byte compare mask. Frame data comes in on a 64-bit stream with valid, start-of-frame and end-of-frame marks. The block checks one qword of eight bytes per beat against all four filters at the same time.

A simple write-only configuration port loads pattern dwords and mask bytes, and turns each filter on or off. The block produces one registered result pulse per frame, with one match bit per filter. The pulse comes when the frame ends or when the beat that carries byte 127 arrives, whichever happens first. Configuration changes made while a frame is in progress are held back: the filter state is captured at each start of frame.

Top module: `pkt_pattern_filter`

## Requirements
- R1: After reset all patterns, masks and enables are zero, and `match_vld_o` and `match_o` are low.
- R2: A configuration write happens when `cfg_we_i` is high, and the write type comes from `cfg_kind_i`. With kind 0, `cfg_data_i` goes to pattern dword `cfg_idx_i` (0..31). With kind 1, `cfg_data_i[7:0]` goes to the mask of qword `cfg_idx_i[3:0]`. With kind 2, `cfg_data_i[0]` becomes the enable of filter `cfg_filt_i`. Kind 3 has no effect.
- R3: Byte k of a beat sits in `rx_data_i[8k+7:8k]`. Pattern qword q is {dword 2q+1, dword 2q}, so pattern byte k of that qword sits at the same bit position as beat byte k.
- R4: Mask bit k of qword q set to 1 requires byte k of beat q to equal the pattern byte. Mask bit k set to 0 ignores that byte.
- R5: A filter matches only when every compared byte of every received qword among the first 16 qwords is equal to its pattern byte.
- R6: A filter does not match if the frame ends before a qword whose mask is non-zero.
- R7: `match_vld_o` is high for exactly one cycle. That cycle is the one right after the end-of-frame beat, or right after beat 15 (bytes 120..127) if that beat comes first. Beats after the result, up to the next start of frame, produce no further result.
- R8: A disabled filter never reports a match.
- R9: A configuration write that lands during a frame affects only frames that start after the write.
- R10: Each filter is judged only on its own pattern, mask and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Write type: 0 pattern dword, 1 mask byte, 2 enable, 3 none |
| cfg_filt_i | input | 2 | Filter selected by the write |
| cfg_idx_i | input | 5 | Dword index (pattern) or qword index (mask) |
| cfg_data_i | input | 32 | Write data |
| rx_valid_i | input | 1 | Beat valid |
| rx_sof_i | input | 1 | Beat is the first of a frame |
| rx_eof_i | input | 1 | Beat is the last of a frame |
| rx_data_i | input | 64 | Eight frame bytes, byte 0 in the low lane |
| match_vld_o | output | 1 | One-cycle pulse that marks a result |
| match_o | output | 4 | Match flag for each filter, valid with `match_vld_o` |

## Verification
The bench runs frames against four kinds of filter setup:
- a full-mask qword, to confirm byte order;
- a partial mask with a difference inside the compared bytes and another with a difference only outside them, to show that mask polarity is right;
- an enabled filter with an all-zero mask, which must match any frame;
- a mask on qword 15, to exercise the 128-byte window edge.

Frames shorter than the last masked qword, and frames longer than 16 beats, show the difference between the end-of-frame result and the window-limit result. A mask change made partway through a frame, followed by a repeat of the same frame, shows that the state captured at start of frame is the one used.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    CFG_PAT  = 2'd0,
    CFG_MSK  = 2'd1,
    CFG_EN   = 2'd2,
    CFG_NONE = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/pf_cfg_store.sv
module pf_cfg_store #(
  parameter int NF  = 4,
  parameter int QN  = 16,
  localparam int FW  = $clog2(NF),
  localparam int QIW = $clog2(QN),
  localparam int IW  = $clog2(QN * 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           kind_i,
  input  logic [FW-1:0]        filt_i,
  input  logic [IW-1:0]        idx_i,
  input  logic [31:0]          data_i,
  input  logic                 snap_i,
  input  logic [QIW-1:0]       qsel_i,
  output logic [NF-1:0][63:0]  pat_o,
  output logic [NF-1:0][7:0]   msk_o,
  output logic [NF-1:0]        en_o,
  output logic [NF-1:0]        tail_zero_o
);
  import pf_pkg::*;

  logic [63:0] pat_cfg [NF][QN];
  logic [63:0] pat_act [NF][QN];
  logic [7:0]  msk_cfg [NF][QN];
  logic [7:0]  msk_act [NF][QN];
  logic [NF-1:0] en_cfg, en_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < NF; f++)
        for (int q = 0; q < QN; q++) begin
          pat_cfg[f][q] <= '0;
          msk_cfg[f][q] <= '0;
        end
      en_cfg <= '0;
    end else if (we_i) begin
      case (cfg_kind_e'(kind_i))
        CFG_PAT: begin
          if (idx_i[0]) pat_cfg[filt_i][idx_i[IW-1:1]][63:32] <= data_i;
          else          pat_cfg[filt_i][idx_i[IW-1:1]][31:0]  <= data_i;
        end
        CFG_MSK: msk_cfg[filt_i][idx_i[QIW-1:0]] <= data_i[7:0];
        CFG_EN:  en_cfg[filt_i] <= data_i[0];
        default: ;
      endcase
    end
  end

  // working copy used by the frame in progress
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < NF; f++)
        for (int q = 0; q < QN; q++) begin
          pat_act[f][q] <= '0;
          msk_act[f][q] <= '0;
        end
      en_act <= '0;
    end else if (snap_i) begin
      pat_act <= pat_cfg;
      msk_act <= msk_cfg;
      en_act  <= en_cfg;
    end
  end

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      pat_o[f]       = snap_i ? pat_cfg[f][qsel_i] : pat_act[f][qsel_i];
      msk_o[f]       = snap_i ? msk_cfg[f][qsel_i] : msk_act[f][qsel_i];
      en_o[f]        = snap_i ? en_cfg[f] : en_act[f];
      tail_zero_o[f] = 1'b1;
      for (int q = 0; q < QN; q++)
        if (q > int'(qsel_i))
          tail_zero_o[f] = tail_zero_o[f] &
                           ((snap_i ? msk_cfg[f][q] : msk_act[f][q]) == 8'h00);
    end
  end

  // R2
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == 2'd2) |=> en_cfg[$past(filt_i)] == $past(data_i[0]));

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(en_act));
endmodule

// File: rtl/pf_lane_cmp.sv
module pf_lane_cmp #(
  parameter int NF = 4
) (
  input  logic [63:0]          beat_i,
  input  logic [NF-1:0][63:0]  pat_i,
  input  logic [NF-1:0][7:0]   msk_i,
  output logic [NF-1:0]        hit_o
);
  for (genvar f = 0; f < NF; f++) begin : g_filt
    logic [7:0] byte_ok;
    for (genvar b = 0; b < 8; b++) begin : g_byte
      assign byte_ok[b] = !msk_i[f][b] || (beat_i[8*b +: 8] == pat_i[f][8*b +: 8]);
    end
    assign hit_o[f] = &byte_ok;
  end
endmodule

// File: rtl/pkt_pattern_filter.sv
module pkt_pattern_filter #(
  parameter int NUM_FILT  = 4,
  parameter int WIN_BYTES = 128,
  localparam int QN  = WIN_BYTES / 8,
  localparam int QIW = $clog2(QN),
  localparam int FW  = $clog2(NUM_FILT),
  localparam int IW  = $clog2(QN * 2)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_kind_i,
  input  logic [FW-1:0]       cfg_filt_i,
  input  logic [IW-1:0]       cfg_idx_i,
  input  logic [31:0]         cfg_data_i,
  input  logic                rx_valid_i,
  input  logic                rx_sof_i,
  input  logic                rx_eof_i,
  input  logic [63:0]         rx_data_i,
  output logic                match_vld_o,
  output logic [NUM_FILT-1:0] match_o
);
  logic                      busy_q;
  logic [QIW-1:0]            qcnt_q, qsel;
  logic [NUM_FILT-1:0]       ok_q, ok_nxt, hit, en_eff, tail_zero;
  logic [NUM_FILT-1:0][63:0] pat_sel;
  logic [NUM_FILT-1:0][7:0]  msk_sel;
  logic                      sof_beat, live, fin;

  assign sof_beat = rx_valid_i && rx_sof_i;
  assign live     = rx_valid_i && (rx_sof_i || busy_q);
  assign qsel     = rx_sof_i ? '0 : qcnt_q;
  assign fin      = live && (rx_eof_i || qsel == QIW'(QN - 1));

  pf_cfg_store #(.NF(NUM_FILT), .QN(QN)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .kind_i      (cfg_kind_i),
    .filt_i      (cfg_filt_i),
    .idx_i       (cfg_idx_i),
    .data_i      (cfg_data_i),
    .snap_i      (sof_beat),
    .qsel_i      (qsel),
    .pat_o       (pat_sel),
    .msk_o       (msk_sel),
    .en_o        (en_eff),
    .tail_zero_o (tail_zero)
  );

  pf_lane_cmp #(.NF(NUM_FILT)) u_cmp (
    .beat_i (rx_data_i),
    .pat_i  (pat_sel),
    .msk_i  (msk_sel),
    .hit_o  (hit)
  );

  assign ok_nxt = (rx_sof_i ? '1 : ok_q) & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      qcnt_q      <= '0;
      ok_q        <= '0;
      match_vld_o <= 1'b0;
      match_o     <= '0;
    end else begin
      match_vld_o <= fin;
      match_o     <= fin ? (ok_nxt & en_eff & tail_zero) : '0;
      if (live) begin
        ok_q   <= ok_nxt;
        qcnt_q <= qsel + 1'b1;
        busy_q <= !fin;
      end
    end
  end

  // R7
  flag_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_vld_o |-> match_o == '0);

  // R7
  result_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_vld_o |-> $past(rx_valid_i));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_vld_o |-> (match_o & ~$past(en_eff)) == '0);
endmodule

// File: tb/pkt_pattern_filter_test.sv
module pkt_pattern_filter_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [1:0]  cfg_filt = '0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [63:0] rx_data = '0;
  logic        match_vld;
  logic [3:0]  match;

  pkt_pattern_filter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind), .cfg_filt_i(cfg_filt),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_data_i(rx_data),
    .match_vld_o(match_vld), .match_o(match)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, pulses = 0, got_cyc = 0;
  logic [3:0]  got = '0;
  logic [63:0] m_pat [4][16];
  logic [7:0]  m_msk [4][16];
  logic [3:0]  m_en = '0;
  logic [63:0] frm [24];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (match_vld) begin pulses++; got = match; got_cyc = cyc; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cfg_wr(input logic [1:0] k, input int f, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_filt = 2'(f); cfg_idx = 5'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_qw(input int f, input int q, input logic [63:0] p, input logic [7:0] m);
    cfg_wr(2'd0, f, 2*q, p[31:0]);
    cfg_wr(2'd0, f, 2*q+1, p[63:32]);
    cfg_wr(2'd1, f, q, {24'h0, m});
    m_pat[f][q] = p; m_msk[f][q] = m;
  endtask

  task automatic set_en(input int f, input bit e);
    cfg_wr(2'd2, f, 0, {31'h0, e});
    m_en[f] = e;
  endtask

  function automatic logic [3:0] expect_of(input int n);
    logic [3:0] r = m_en;
    for (int f = 0; f < 4; f++)
      for (int q = 0; q < 16; q++) begin
        if (q < n) begin
          for (int b = 0; b < 8; b++)
            if (m_msk[f][q][b] && frm[q][8*b +: 8] != m_pat[f][q][8*b +: 8]) r[f] = 1'b0;
        end else if (m_msk[f][q] != 8'h00) r[f] = 1'b0;
      end
    return r;
  endfunction

  // sends n beats; optional mask write to filter mf qword mq at beat mid (-1 none)
  task automatic send(input string req, input int n, input int mid, input int mf,
                      input int mq, input logic [7:0] mm);
    logic [3:0] e = expect_of(n);
    int term = (n < 16) ? n - 1 : 15;
    int ecyc = 0;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = frm[i];
      if (i == mid) begin
        cfg_we = 1'b1; cfg_kind = 2'd1; cfg_filt = 2'(mf); cfg_idx = 5'(mq); cfg_data = {24'h0, mm};
      end else cfg_we = 1'b0;
      @(posedge clk); #1;
      if (i == term) ecyc = cyc;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    if (mid >= 0) m_msk[mf][mq] = mm;
    chk(pulses == 1, {req, " R7 pulse count"}, pulses, 1);
    chk(got_cyc == ecyc, {req, " R7 result cycle"}, got_cyc, ecyc);
    chk(got == e, {req, " match"}, int'(got), int'(e));
  endtask

  task automatic t_reset();
    chk(match_vld == 1'b0 && match == 4'h0, "R1 outputs after reset", {match_vld, match}, 0);
    for (int i = 0; i < 4; i++) frm[i] = 64'h0;
    send("R1 R8 all disabled", 4, -1, 0, 0, 8'h0);
  endtask

  task automatic t_basic();
    set_qw(0, 0, 64'h1122_3344_5566_7788, 8'hFF);
    set_qw(0, 2, 64'hAABB_CCDD_0102_0304, 8'h0F);
    set_en(0, 1'b1);
    set_en(1, 1'b1);
    frm[0] = 64'h1122_3344_5566_7788;
    frm[1] = 64'hDEAD_BEEF_0BAD_F00D;
    frm[2] = 64'h9999_9999_0102_0304;
    frm[3] = 64'h0;
    send("R3 R4 R5 R10 match; differ outside mask", 4, -1, 0, 0, 8'h0);
    chk(got == 4'b0011, "R4 R10 explicit", got, 4'b0011);
    frm[2] = 64'hAABB_CCDD_0102_0305;
    send("R4 R5 differ inside mask", 4, -1, 0, 0, 8'h0);
    chk(got[0] == 1'b0 && got[1] == 1'b1, "R5 R10 explicit", got, 4'b0010);
    frm[2] = 64'hAABB_CCDD_0102_0304;
    frm[0] = 64'h1122_3344_5566_7789;
    send("R3 R5 qword0 low byte", 4, -1, 0, 0, 8'h0);
  endtask

  task automatic t_short();
    frm[0] = 64'h1122_3344_5566_7788;
    send("R6 frame ends before masked qword", 2, -1, 0, 0, 8'h0);
    chk(got == 4'b0010, "R6 explicit", got, 4'b0010);
  endtask

  task automatic t_window();
    set_qw(2, 15, 64'h0F0E_0D0C_0B0A_0908, 8'hFF);
    set_en(2, 1'b1);
    for (int i = 0; i < 24; i++) frm[i] = 64'(i) * 64'h0101_0101_0101_0101;
    frm[15] = 64'h0F0E_0D0C_0B0A_0908;
    send("R7 long frame, window limit", 20, -1, 0, 0, 8'h0);
    chk(got[2] == 1'b1, "R5 qword15 compared", got, 4'b0100);
    frm[15] = 64'h8F0E_0D0C_0B0A_0908;
    send("R4 qword15 top byte differs", 20, -1, 0, 0, 8'h0);
    send("R6 window qword absent", 8, -1, 0, 0, 8'h0);
  endtask

  task automatic t_midframe();
    frm[0] = 64'h1122_3344_5566_7788;
    frm[1] = 64'h5555_5555_5555_5555;
    frm[2] = 64'hAABB_CCDD_0102_0304;
    frm[3] = 64'h0;
    send("R9 mid-frame write deferred", 4, 1, 0, 1, 8'h01);
    chk(got[0] == 1'b1, "R9 old mask used", got, 4'b0011);
    send("R9 new mask next frame", 4, -1, 0, 0, 8'h0);
    chk(got[0] == 1'b0, "R9 new mask applied", got, 4'b0010);
  endtask

  task automatic t_disable();
    set_en(1, 1'b0);
    cfg_wr(2'd3, 1, 0, 32'h1);
    send("R8 R2 filter1 off, kind3 ignored", 4, -1, 0, 0, 8'h0);
    chk(got[1] == 1'b0, "R8 disabled", got, 4'b0000);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int f = 0; f < 4; f++)
      for (int q = 0; q < 16; q++) begin m_pat[f][q] = '0; m_msk[f][q] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_short();
    t_window();
    t_midframe();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule